// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of peripheral DMA request lines and the channels of a DMA transfer engine. Every request line owns one small programmable map entry. The entry either names a destination channel and marks the route as valid, or leaves the line unrouted. Software reads and writes the entries through a simple word-addressed register port. The low-numbered request lines have their entries in one address window, and the remaining lines have theirs in a second window higher up.

For each channel the block registers a request level. That level is the OR of every valid request line that is routed to the channel. The block also watches that level for edges. A rising edge gives a one-cycle request-after-stop pulse to the channel status logic, and a falling edge gives a one-cycle end-of-receive pulse. Any rising edge also gives a one-cycle kick that asks the transfer engine for a scheduling pass. If a write tries to enable a route to a channel that does not exist, an error pulse is raised and the entry is stored with its valid bit cleared.

Top module: `dreq_mapper`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every output is zero. Every map entry resets to 0x00, which means no route is valid.
- R2: A map entry is 8 bits wide. Bits 4..0 hold the channel number, bit 7 is the valid flag, and bits 6..5 are stored exactly as written. The entry for request i (i < 64) is at byte address 0x100 + 4*i. The entry for request i (64 <= i < 75) is at 0x1100 + 4*(i-64). The value read with rd_en appears on rdata on the cycle after the read. In any cycle that does not follow a read, rdata is zero.
- R3: An address that is outside both windows, or that is not a multiple of four, changes no map entry, and a read of it returns zero.
- R4: A request line whose map entry has bit 7 clear has no effect on any channel output.
- R5: One cycle after the inputs are sampled, ch_req[c] is the OR of all request lines whose entry has bit 7 set and a channel field equal to c.
- R6: ras_pulse[c] is high for exactly one cycle, in the cycle where ch_req[c] goes from 0 to 1.
- R7: eor_pulse[c] is high for exactly one cycle, in the cycle where ch_req[c] goes from 1 to 0.
- R8: sched_kick is high in exactly those cycles where at least one ras_pulse bit is high.
- R9: A write to a valid map address with bit 7 set and a channel field >= NUM_CH raises map_err in the next cycle. That entry is then stored with bit 7 cleared. Any other write leaves map_err low.
- R10: Rewriting the entry of a request that is being held moves that request. One cycle after the write takes effect, the old channel shows an end-of-receive pulse and the new channel shows a request-after-stop pulse, both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_in | input | NUM_REQ | Peripheral request levels, bit i = request line i |
| wr_en | input | 1 | Write strobe for the map register port |
| rd_en | input | 1 | Read strobe for the map register port |
| addr | input | AW | Byte address for the read or write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after rd_en |
| map_err | output | 1 | One-cycle pulse when a route to a nonexistent channel is rejected |
| ch_req | output | NUM_CH | Registered per-channel request level |
| ras_pulse | output | NUM_CH | Per-channel request-after-stop pulse (rising edge) |
| eor_pulse | output | NUM_CH | Per-channel end-of-receive pulse (falling edge) |
| sched_kick | output | 1 | Scheduling-pass request, high when any channel request rises |

## Verification
The bench builds the block with all 75 request lines and with NUM_CH set to 20. A channel count that is not a power of two means the 5-bit channel field can name channels 20 to 31, which do not exist. That makes the rejection path and the valid-bit clearing reachable. With all request lines present, both address windows are exercised, including the first entry and the last entry of the upper window. Directed cases cover the OR-merging of several requests onto one channel and a route being moved while its request is held. A long random phase of request toggles, map writes and reads is then compared on every cycle against a behavioural model.

// File: rtl/dreq_map_pkg.sv
package dreq_map_pkg;

  localparam int unsigned MAP_W    = 8;
  localparam int unsigned CHF_W    = 5;
  localparam int unsigned MAX_CH   = 1 << CHF_W;

  typedef struct packed {
    logic             valid;
    logic [1:0]       spare;
    logic [CHF_W-1:0] chan;
  } map_entry_t;

endpackage

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
  import dreq_map_pkg::*;
#(
  parameter int unsigned NUM_REQ  = 75,
  parameter int unsigned NUM_CH   = 32,
  parameter int unsigned LO_COUNT = 64,
  parameter int unsigned AW       = 16,
  parameter logic [AW-1:0] LO_BASE = 16'h0100,
  parameter logic [AW-1:0] HI_BASE = 16'h1100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [MAP_W-1:0]    wdata,
  output logic [MAP_W-1:0]    rdata,
  output logic                map_err,
  output map_entry_t          map_o [NUM_REQ]
);

  localparam int unsigned IDX_W    = $clog2(NUM_REQ);
  localparam int unsigned HI_COUNT = NUM_REQ - LO_COUNT;
  localparam logic [AW-3:0] LO_LIM = (AW-2)'(LO_COUNT);
  localparam logic [AW-3:0] HI_LIM = (AW-2)'(HI_COUNT);
  localparam logic [IDX_W-1:0] HI_FIRST = IDX_W'(LO_COUNT);
  localparam logic [CHF_W:0] CH_LIM = (CHF_W+1)'(NUM_CH);

  map_entry_t       map_q [NUM_REQ];
  map_entry_t       map_d [NUM_REQ];
  logic [MAP_W-1:0] rdata_d;
  logic             err_d;

  logic [AW-1:0]    lo_off;
  logic [AW-1:0]    hi_off;
  logic             lo_hit;
  logic             hi_hit;
  logic             hit;
  logic [IDX_W-1:0] idx;
  map_entry_t       wr_ent;
  logic             bad_ch;

  // address decode into the two windows
  always_comb begin
    lo_off = addr - LO_BASE;
    hi_off = addr - HI_BASE;
    lo_hit = (addr >= LO_BASE) && (lo_off[1:0] == 2'b00) && (lo_off[AW-1:2] < LO_LIM);
    hi_hit = (HI_COUNT != 0) && (addr >= HI_BASE) && (hi_off[1:0] == 2'b00) &&
             (hi_off[AW-1:2] < HI_LIM);
    hit    = lo_hit || hi_hit;
    if (lo_hit) idx = IDX_W'(lo_off[AW-1:2]);
    else        idx = IDX_W'(hi_off[AW-1:2]) + HI_FIRST;
  end

  // write data screening: a route to a missing channel loses its valid bit
  always_comb begin
    wr_ent = map_entry_t'(wdata);
    bad_ch = wr_ent.valid && ({1'b0, wr_ent.chan} >= CH_LIM);
    if (bad_ch) wr_ent.valid = 1'b0;
  end

  // next-state
  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      map_d[r] = map_q[r];
      if (wr_en && hit && (idx == IDX_W'(r))) map_d[r] = wr_ent;
    end
    err_d   = wr_en && hit && bad_ch;
    rdata_d = '0;
    if (rd_en && hit) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (idx == IDX_W'(r)) rdata_d = MAP_W'(map_q[r]);
      end
    end
  end

  // registers
  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q[g] <= '0;
        else if (wr_en) map_q[g] <= map_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      map_err <= 1'b0;
    end else begin
      rdata   <= rdata_d;
      map_err <= err_d;
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_map_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic [NUM_REQ-1:0] req_in,
  input  map_entry_t         map_i [NUM_REQ],
  output logic [NUM_CH-1:0]  ch_level
);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [NUM_REQ-1:0] hits;
      for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        assign hits[r] = req_in[r] && map_i[r].valid &&
                         (map_i[r].chan == CHF_W'(c));
      end
      assign ch_level[c] = |hits;
    end
  endgenerate

endmodule

// File: rtl/dreq_edge.sv
module dreq_edge #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] level_d,
  output logic [NUM_CH-1:0] level_q,
  output logic [NUM_CH-1:0] rise_q,
  output logic [NUM_CH-1:0] fall_q,
  output logic              kick_q
);

  logic [NUM_CH-1:0] rise_d;
  logic [NUM_CH-1:0] fall_d;
  logic              kick_d;

  always_comb begin
    rise_d = level_d & ~level_q;
    fall_d = ~level_d & level_q;
    kick_d = |rise_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      kick_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      kick_q  <= kick_d;
    end
  end

endmodule

// File: rtl/dreq_mapper.sv
module dreq_mapper
  import dreq_map_pkg::*;
#(
  parameter int unsigned NUM_REQ  = 75,
  parameter int unsigned NUM_CH   = 32,
  parameter int unsigned LO_COUNT = 64,
  parameter int unsigned AW       = 16,
  parameter logic [AW-1:0] LO_BASE = 16'h0100,
  parameter logic [AW-1:0] HI_BASE = 16'h1100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REQ-1:0]  req_in,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic                map_err,
  output logic [NUM_CH-1:0]   ch_req,
  output logic [NUM_CH-1:0]   ras_pulse,
  output logic [NUM_CH-1:0]   eor_pulse,
  output logic                sched_kick
);

  map_entry_t        map_w [NUM_REQ];
  logic [NUM_CH-1:0] level_w;

  dreq_map_regs #(
    .NUM_REQ (NUM_REQ),
    .NUM_CH  (NUM_CH),
    .LO_COUNT(LO_COUNT),
    .AW      (AW),
    .LO_BASE (LO_BASE),
    .HI_BASE (HI_BASE)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .map_err(map_err),
    .map_o  (map_w)
  );

  dreq_router #(
    .NUM_REQ(NUM_REQ),
    .NUM_CH (NUM_CH)
  ) router_i (
    .req_in  (req_in),
    .map_i   (map_w),
    .ch_level(level_w)
  );

  dreq_edge #(
    .NUM_CH(NUM_CH)
  ) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_d(level_w),
    .level_q(ch_req),
    .rise_q (ras_pulse),
    .fall_q (eor_pulse),
    .kick_q (sched_kick)
  );

endmodule

// File: rtl/dreq_mapper_chk.sv
module dreq_mapper_chk #(
  parameter int unsigned NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              map_err,
  input logic [NUM_CH-1:0] ch_req,
  input logic [NUM_CH-1:0] ras_pulse,
  input logic [NUM_CH-1:0] eor_pulse,
  input logic              sched_kick
);

  assert_ras_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pulse & ~(ch_req & ~$past(ch_req))) == '0);

  assert_eor_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse & ~(~ch_req & $past(ch_req))) == '0);

  assert_edges_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pulse & eor_pulse) == '0);

  assert_kick_tracks_ras_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sched_kick == (ras_pulse != '0));

  assert_err_needs_valid_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> ($past(wr_en) && $past(wdata[7])));

  assert_rdata_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (rdata == 8'h00));

endmodule

bind dreq_mapper dreq_mapper_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .map_err   (map_err),
  .ch_req    (ch_req),
  .ras_pulse (ras_pulse),
  .eor_pulse (eor_pulse),
  .sched_kick(sched_kick)
);

// File: tb/dreq_mapper_tb_top.sv
module dreq_mapper_tb_top;

  localparam int NREQ = 75;
  localparam int NCH  = 20;

  logic             clk;
  logic             rst_n;
  logic [NREQ-1:0]  req_in;
  logic             wr_en;
  logic             rd_en;
  logic [15:0]      addr;
  logic [7:0]       wdata;
  logic [7:0]       rdata;
  logic             map_err;
  logic [NCH-1:0]   ch_req;
  logic [NCH-1:0]   ras_pulse;
  logic [NCH-1:0]   eor_pulse;
  logic             sched_kick;

  int check_cnt = 0;
  int err_cnt   = 0;
  bit done      = 0;

  dreq_mapper #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .map_err(map_err),
    .ch_req(ch_req), .ras_pulse(ras_pulse), .eor_pulse(eor_pulse),
    .sched_kick(sched_kick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int             m_map [NREQ];
  logic [NCH-1:0] m_prev;
  logic [NCH-1:0] e_ch, e_ras, e_eor;
  logic           e_kick, e_err;
  logic [7:0]     e_rdata;

  function automatic logic [15:0] map_addr(int i);
    if (i < 64) return 16'(32'h100 + 4 * i);
    return 16'(32'h1100 + 4 * (i - 64));
  endfunction

  function automatic int find_idx(logic [15:0] a);
    for (int i = 0; i < NREQ; i++) if (map_addr(i) == a) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREQ; i++) m_map[i] = 0;
      m_prev = '0; e_ch = '0; e_ras = '0; e_eor = '0;
      e_kick = 0; e_err = 0; e_rdata = 0;
    end else begin
      int k;
      logic [NCH-1:0] nxt;
      k = find_idx(addr);
      e_rdata = (rd_en && k >= 0) ? 8'(m_map[k]) : 8'h00;
      nxt = '0;
      for (int i = 0; i < NREQ; i++)
        if (req_in[i] && m_map[i][7] && (m_map[i] % 32) < NCH)
          nxt[m_map[i] % 32] = 1'b1;
      e_ras  = nxt & ~m_prev;
      e_eor  = ~nxt & m_prev;
      e_kick = (e_ras != '0);
      e_ch   = nxt;
      m_prev = nxt;
      e_err  = 0;
      if (wr_en && k >= 0) begin
        if (wdata[7] && int'(wdata[4:0]) >= NCH) begin
          e_err = 1;
          m_map[k] = int'(wdata & 8'h7F);
        end else begin
          m_map[k] = int'(wdata);
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    check_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ch_req == e_ch, "R5 ch_req model", 32'(ch_req), 32'(e_ch));
      chk(ras_pulse == e_ras, "R6 ras model", 32'(ras_pulse), 32'(e_ras));
      chk(eor_pulse == e_eor, "R7 eor model", 32'(eor_pulse), 32'(e_eor));
      chk(sched_kick == e_kick, "R8 kick model", 32'(sched_kick), 32'(e_kick));
      chk(map_err == e_err, "R9 err model", 32'(map_err), 32'(e_err));
      chk(rdata == e_rdata, "R2 rdata model", 32'(rdata), 32'(e_rdata));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [15:0] a, logic [7:0] exp, string tag);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    chk(rdata == exp, tag, 32'(rdata), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", check_cnt, err_cnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_in = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    repeat (3) tick();
    chk({ch_req, ras_pulse, eor_pulse, sched_kick, map_err, rdata} == '0,
        "R1 outputs in reset", 32'(ch_req), 32'h0);
    rst_n = 1'b1;
    tick();
    chk(ch_req == '0 && rdata == 8'h00, "R1 outputs after release", 32'(ch_req), 32'h0);
    do_read(16'h0100, 8'h00, "R1 entry reset value");
    do_read(map_addr(74), 8'h00, "R1 last entry reset value");

    // R2 programming and readback in both windows
    do_write(16'h0100, 8'h83);
    chk(map_err == 1'b0, "R9 no err on good write", 32'(map_err), 32'h0);
    do_read(16'h0100, 8'h83, "R2 readback low window");
    do_write(map_addr(70), 8'hE5);
    do_read(map_addr(70), 8'hE5, "R2 readback high window");

    // R3 unmapped and misaligned addresses
    do_write(16'h0102, 8'h81);
    do_write(16'h112C, 8'h81);
    do_read(16'h0100, 8'h83, "R3 misaligned write ignored");
    do_read(16'h0102, 8'h00, "R3 misaligned read zero");
    do_read(16'h112C, 8'h00, "R3 beyond window read zero");

    // R4 invalid entry is ignored
    do_write(map_addr(1), 8'h03);
    req_in[1] = 1'b1;
    tick(); tick();
    chk(ch_req == '0 && ras_pulse == '0, "R4 invalid route ignored", 32'(ch_req), 32'h0);

    // R5 / R6 / R8 routing and rising edge
    req_in[0] = 1'b1;
    tick();
    chk(ch_req == NCH'(1 << 3), "R5 route to ch3", 32'(ch_req), 32'h8);
    chk(ras_pulse == NCH'(1 << 3), "R6 ras on rise", 32'(ras_pulse), 32'h8);
    chk(sched_kick == 1'b1, "R8 kick on rise", 32'(sched_kick), 32'h1);
    tick();
    chk(ras_pulse == '0 && sched_kick == 1'b0, "R6 ras single cycle", 32'(ras_pulse), 32'h0);

    // R5 OR of two requests on one channel
    do_write(map_addr(2), 8'h83);
    req_in[2] = 1'b1;
    tick();
    req_in[0] = 1'b0;
    tick(); tick();
    chk(ch_req == NCH'(1 << 3) && eor_pulse == '0, "R5 OR merge keeps ch3",
        32'(ch_req), 32'h8);

    // R7 falling edge
    req_in[2] = 1'b0;
    tick();
    chk(eor_pulse == NCH'(1 << 3) && ch_req == '0, "R7 eor on fall", 32'(eor_pulse), 32'h8);

    // R10 move a held request
    req_in[70] = 1'b1;
    tick();
    chk(ras_pulse == NCH'(1 << 5), "R6 ras on ch5", 32'(ras_pulse), 32'h20);
    do_write(map_addr(70), 8'h87);
    tick();
    chk(eor_pulse == NCH'(1 << 5) && ras_pulse == NCH'(1 << 7) && ch_req == NCH'(1 << 7),
        "R10 remap moves request", 32'(ch_req), 32'h80);

    // R9 route to a missing channel
    do_write(map_addr(10), 8'h99);
    chk(map_err == 1'b1, "R9 err on bad channel", 32'(map_err), 32'h1);
    do_read(map_addr(10), 8'h19, "R9 stored with valid cleared");
    req_in[10] = 1'b1;
    tick(); tick();
    chk(ch_req == NCH'(1 << 7), "R9 rejected route inert", 32'(ch_req), 32'h80);
    do_write(map_addr(11), 8'h93);
    chk(map_err == 1'b0, "R9 top channel accepted", 32'(map_err), 32'h0);
    do_read(map_addr(11), 8'h93, "R9 top channel readback");

    // random phase, checked against the model each cycle
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < NREQ; b++)
        if ($urandom_range(0, 15) == 0) req_in[b] = ~req_in[b];
      wr_en = ($urandom_range(0, 3) == 0);
      rd_en = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) addr = 16'($urandom);
      else addr = map_addr(int'($urandom_range(0, NREQ - 1)));
      wdata = 8'($urandom);
      tick();
    end
    wr_en = 0; rd_en = 0;
    tick(); tick();
    finish_run();
  end

endmodule